// File: doc/BRIEF.md
# Windowed Watchdog Reset Timer

This block is a watchdog counter that asks the system reset controller for a reset when software stops servicing it. Software services the watchdog by writing two key bytes to a single service address: first 0x55, then 0xAA. The pair completes when 0xAA arrives and the 0x55 before it was the previous accepted write. A completed pair restarts the count from zero. A write of any other byte to that address requests a reset at once. These writes are only strobes into the block. They do not change any read-only status data that shares the address, which lives outside this block.

Two plain configuration inputs choose the count clock and the timeout. The count clock is either every bus clock cycle or a slow 1 kHz tick, which arrives as a one-cycle clock-enable strobe. The timeout select is a 2-bit field. The value 00 turns the watchdog off, and 01, 10 and 11 give short, medium and long timeouts. The reset values of the surrounding options register are 1 kHz source and select 11. When the bus clock is the source, a window option can be set. With the window set, a key write is accepted only in the last quarter of the timeout, and an earlier write requests a reset. All pins are plain control and data signals with no valid/ready handshake. A service write is taken in the cycle its strobe is high, and the block never applies back-pressure.

Top module: `wdg_window_timer`

## Requirements
- R1: A write of 0xAA that directly follows an accepted write of 0x55 restarts the count from zero in the next cycle. No reset request is raised for it.
- R2: With the watchdog on, a write of any byte other than 0x55 or 0xAA raises `rst_req` in the next cycle. It also clears the count and the key state.
- R3: A write of 0xAA with no 0x55 directly before it does not restart the count and raises no reset. The key checker goes back to waiting for 0x55 after every completed or broken pair.
- R4: With the bus clock as source, select 01, 10 and 11 time out after 2^13, 2^16 and 2^18 count steps since the last restart. On a timeout, `rst_req` goes high for one cycle, in the cycle after the final step.
- R5: Select 00 turns the watchdog off. The count stays at zero, service writes are ignored, and `rst_req` stays low.
- R6: With the 1 kHz source (`src_bus_clk` = 0), the count advances only in cycles where `tick_1k` is high. The timeouts are 2^5, 2^8 and 2^10 ticks.
- R7: When `window_en` = 1 and the bus clock is the source, a key write (0x55 or 0xAA) made while the count is below three quarters of the timeout raises `rst_req` in the next cycle. For select 01 that threshold is 6144. A write at or above the threshold is accepted.
- R8: `window_en` has no effect while the 1 kHz source is selected.
- R9: Any change of `src_bus_clk` or `tmo_sel` clears the count and the key state, so the next period starts from zero.
- R10: Reset leaves `rst_req` low, the count at zero and the key checker waiting for 0x55.
- R11: A pair that completes in the same cycle as the final count step takes priority over the timeout, so no reset is raised.
- R12: Each timeout produces exactly one single-cycle pulse on `rst_req`, and the count then starts a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1k | input | 1 | One-cycle 1 kHz clock-enable strobe |
| src_bus_clk | input | 1 | Count source: 1 = bus clock, 0 = 1 kHz tick |
| tmo_sel | input | 2 | Timeout select: 00 off, 01 short, 10 medium, 11 long |
| window_en | input | 1 | Window option, used only with the bus clock source |
| svc_wr | input | 1 | Write strobe for the service address |
| svc_data | input | 8 | Byte written to the service address |
| rst_req | output | 1 | Single-cycle system reset request |

## Verification
The service function is driven with several kinds of stimulus, and each one separates a different fault:
- A proper pair at mid-period separates restart from no restart.
- A lone 0xAA, which must still time out on the original schedule, separates a pair-order check from a checker that restarts on any 0xAA.
- A foreign byte separates the immediate fault path from the normal timeout path.
- A pair whose 0xAA lands on the terminal step separates correct priority from a timeout that wins the tie.

Window writes are placed one count below and exactly at the opening threshold, with both a 0x55 and a lone 0xAA. The same early pair is also made with the 1 kHz source, where it must pass, which shows that the window is ignored there.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    SEL_OFF   = 2'b00,
    SEL_SHORT = 2'b01,
    SEL_MED   = 2'b10,
    SEL_LONG  = 2'b11
  } tmo_sel_e;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdg_timebase.sv
module wdg_timebase
  import wdg_pkg::*;
#(
  parameter int unsigned SLOW_EXP_S = 5,
  parameter int unsigned SLOW_EXP_M = 8,
  parameter int unsigned SLOW_EXP_L = 10,
  parameter int unsigned BUS_EXP_S  = 13,
  parameter int unsigned BUS_EXP_M  = 16,
  parameter int unsigned BUS_EXP_L  = 18,
  parameter int unsigned CW         = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1k,
  input  logic          src_bus_clk,
  input  logic [1:0]    tmo_sel,
  input  logic          window_en,
  output logic          step,
  output logic          enabled,
  output logic          cfg_chg,
  output logic          win_active,
  output logic [CW-1:0] term,
  output logic [CW-1:0] win_open
);

  localparam int unsigned SPAN_W = CW + 1;

  logic              src_q;
  tmo_sel_e          sel_q;
  tmo_sel_e          sel_now;
  int unsigned       exp_sel;
  logic [SPAN_W-1:0] span;

  assign sel_now = tmo_sel_e'(tmo_sel);

  // previous configuration, reset to the options-register defaults
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      sel_q <= SEL_LONG;
    end else begin
      src_q <= src_bus_clk;
      sel_q <= sel_now;
    end
  end

  assign cfg_chg    = (src_q != src_bus_clk) || (sel_q != sel_now);
  assign enabled    = (sel_now != SEL_OFF);
  assign step       = src_bus_clk | tick_1k;
  assign win_active = window_en & src_bus_clk;

  always_comb begin
    if (src_bus_clk) begin
      unique case (sel_now)
        SEL_SHORT: exp_sel = BUS_EXP_S;
        SEL_MED:   exp_sel = BUS_EXP_M;
        default:   exp_sel = BUS_EXP_L;
      endcase
    end else begin
      unique case (sel_now)
        SEL_SHORT: exp_sel = SLOW_EXP_S;
        SEL_MED:   exp_sel = SLOW_EXP_M;
        default:   exp_sel = SLOW_EXP_L;
      endcase
    end
  end

  always_comb begin
    span     = SPAN_W'(1) << exp_sel;
    term     = CW'(span - SPAN_W'(1));
    win_open = CW'(span - (span >> 2));
  end

endmodule

// File: rtl/wdg_keycheck.sv
module wdg_keycheck
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       enabled,
  input  logic       early,
  input  logic       clear,
  output logic       fault,
  output logic       service,
  output logic       armed
);

  key_state_e key_q;
  logic       active;
  logic       foreign;

  assign active  = wr_en & enabled;
  assign foreign = (wr_data != KEY_FIRST) && (wr_data != KEY_SECOND);
  assign fault   = active & (foreign | early);
  assign service = active & ~fault & (wr_data == KEY_SECOND) & (key_q == KEY_ARMED);
  assign armed   = (key_q == KEY_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= KEY_IDLE;
    end else if (!enabled || clear || fault) begin
      key_q <= KEY_IDLE;
    end else if (active) begin
      key_q <= (wr_data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
    end
  end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          hold,
  input  logic          restart,
  input  logic [CW-1:0] term,
  output logic [CW-1:0] count,
  output logic          expire
);

  assign expire = step & ~hold & ~restart & (count == term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (hold || restart || expire) begin
      count <= '0;
    end else if (step) begin
      count <= count + CW'(1);
    end
  end

endmodule

// File: rtl/wdg_window_timer.sv
module wdg_window_timer
  import wdg_pkg::*;
#(
  parameter int unsigned SLOW_EXP_S = 5,
  parameter int unsigned SLOW_EXP_M = 8,
  parameter int unsigned SLOW_EXP_L = 10,
  parameter int unsigned BUS_EXP_S  = 13,
  parameter int unsigned BUS_EXP_M  = 16,
  parameter int unsigned BUS_EXP_L  = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1k,
  input  logic       src_bus_clk,
  input  logic [1:0] tmo_sel,
  input  logic       window_en,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       rst_req
);

  localparam int unsigned CW = max_of3(max_of3(SLOW_EXP_S, SLOW_EXP_M, SLOW_EXP_L),
                                       max_of3(BUS_EXP_S, BUS_EXP_M, BUS_EXP_L), 2);

  logic          step, enabled, cfg_chg, win_active;
  logic [CW-1:0] term, win_open, count_q;
  logic          early, fault, service, key_armed, expire;

  wdg_timebase #(
    .SLOW_EXP_S(SLOW_EXP_S), .SLOW_EXP_M(SLOW_EXP_M), .SLOW_EXP_L(SLOW_EXP_L),
    .BUS_EXP_S(BUS_EXP_S),   .BUS_EXP_M(BUS_EXP_M),   .BUS_EXP_L(BUS_EXP_L),
    .CW(CW)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .src_bus_clk(src_bus_clk),
    .tmo_sel(tmo_sel), .window_en(window_en), .step(step), .enabled(enabled),
    .cfg_chg(cfg_chg), .win_active(win_active), .term(term), .win_open(win_open)
  );

  // window check sees the count before this cycle's step
  assign early = win_active & (count_q < win_open);

  wdg_keycheck u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(svc_wr), .wr_data(svc_data),
    .enabled(enabled), .early(early), .clear(cfg_chg),
    .fault(fault), .service(service), .armed(key_armed)
  );

  wdg_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .hold(~enabled | cfg_chg),
    .restart(service | fault), .term(term), .count(count_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= fault | expire;
  end

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       src_bus_clk,
  input logic [1:0] tmo_sel,
  input logic       window_en,
  input logic       svc_wr,
  input logic [7:0] svc_data,
  input logic       rst_req,
  input logic       cnt_zero,
  input logic       key_armed
);

  // R1: completed pair restarts the count without a reset
  p_service_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && svc_data == 8'hAA && key_armed && tmo_sel != 2'b00 &&
     !(window_en && src_bus_clk)) |=> (cnt_zero && !rst_req));

  // R2: foreign byte requests a reset in the next cycle
  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && tmo_sel != 2'b00 && svc_data != 8'h55 && svc_data != 8'hAA)
    |=> rst_req);

  // R12: every request leaves the count at the start of a fresh period
  p_clear_on_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> cnt_zero);

  // R5: switched off means no count and no request
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel == 2'b00) |=> (!rst_req && cnt_zero));

  // R9: configuration change clears count and key state
  p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (src_bus_clk != $past(src_bus_clk) || tmo_sel != $past(tmo_sel)))
    |=> (cnt_zero && !key_armed));

endmodule

bind wdg_window_timer wdg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .src_bus_clk(src_bus_clk), .tmo_sel(tmo_sel),
  .window_en(window_en), .svc_wr(svc_wr), .svc_data(svc_data), .rst_req(rst_req),
  .cnt_zero(count_q == '0), .key_armed(key_armed)
);

// File: tb/tb_wdg_window_timer.sv
`timescale 1ns/1ps
module tb_wdg_window_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1k = 1'b0;
  logic       src_bus_clk = 1'b0;
  logic [1:0] tmo_sel = 2'b11;
  logic       window_en = 1'b0;
  logic       svc_wr = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic       rst_req;

  always #2.5 clk = ~clk;

  wdg_window_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .src_bus_clk(src_bus_clk),
    .tmo_sel(tmo_sel), .window_en(window_en), .svc_wr(svc_wr),
    .svc_data(svc_data), .rst_req(rst_req)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    npulse  = 0;
  int    cycles  = 0;
  int    tdiv    = 0;
  bit    done    = 1'b0;
  string cur_req = "R10";

  // behavioural reference state
  int         m_cnt   = 0;
  bit         m_armed = 1'b0;
  bit         m_rst   = 1'b0;
  bit         p_bus   = 1'b0;
  logic [1:0] p_sel   = 2'b11;

  function automatic int period(bit bus, logic [1:0] s);
    int e;
    if (bus) e = (s == 2'b01) ? 13 : (s == 2'b10) ? 16 : 18;
    else     e = (s == 2'b01) ? 5  : (s == 2'b10) ? 8  : 10;
    return 1 << e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_armed = 1'b0; m_rst = 1'b0; p_bus = 1'b0; p_sel = 2'b11;
    end else begin
      bit on, chg, flt, svc, tmo, stp;
      int per;
      on  = (tmo_sel != 2'b00);
      chg = (src_bus_clk != p_bus) || (tmo_sel != p_sel);
      per = period(src_bus_clk, tmo_sel);
      stp = src_bus_clk || tick_1k;
      flt = 1'b0; svc = 1'b0;
      if (on && svc_wr) begin
        if ((svc_data != 8'h55 && svc_data != 8'hAA) ||
            (window_en && src_bus_clk && m_cnt < per - per / 4)) flt = 1'b1;
        else if (svc_data == 8'hAA && m_armed) svc = 1'b1;
      end
      tmo = on && !chg && !flt && !svc && stp && (m_cnt == per - 1);
      if (!on || chg || flt) m_armed = 1'b0;
      else if (svc_wr) m_armed = (svc_data == 8'h55);
      if (!on || chg || flt || svc || tmo) m_cnt = 0;
      else if (stp) m_cnt = m_cnt + 1;
      m_rst = flt || tmo;
      p_bus = src_bus_clk;
      p_sel = tmo_sel;
    end
  end

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      n_tests++;
      if (rst_req !== m_rst) begin
        n_fail++;
        $display("FAIL %s cycle %0d rst_req actual=%0b expected=%0b", cur_req, cycles, rst_req, m_rst);
      end
      if (rst_req === 1'b1) npulse++;
      if (cycles > 190000) begin
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  // 1 kHz strobe stand-in: one cycle in every two
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 2;
    tick_1k = (tdiv == 0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    svc_wr = 1'b1; svc_data = d;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic pair();
    svc_wr = 1'b1; svc_data = 8'h55;
    @(negedge clk);
    svc_data = 8'hAA;
    @(negedge clk);
    svc_wr = 1'b0;
  endtask

  task automatic wait_cnt(input int t);
    while (m_cnt != t) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    cyc(4);
    chk(rst_req === 1'b0, "R10 reset state", rst_req, 0);
    rst_n = 1'b1;
    cyc(1);
    chk(rst_req === 1'b0, "R10 after release", rst_req, 0);

    // R6: 1 kHz source, long timeout = 1024 ticks = 2048 cycles here
    cur_req = "R6"; npulse = 0; cyc(2100);
    chk(npulse == 1, "R6 slow long timeout", npulse, 1);

    // R12/R9: short slow timeout repeats, one pulse each
    cur_req = "R12"; tmo_sel = 2'b01; npulse = 0; cyc(200);
    chk(npulse == 3, "R12 repeated single pulses", npulse, 3);

    // R8: early pair with window set but slow source is accepted
    cur_req = "R8"; window_en = 1'b1; npulse = 0; pair(); cyc(4);
    chk(npulse == 0, "R8 window ignored on slow source", npulse, 0);
    window_en = 1'b0;

    // R9: change select mid-period restarts the period
    cur_req = "R9"; tmo_sel = 2'b10; npulse = 0; cyc(400);
    tmo_sel = 2'b11; cyc(1); tmo_sel = 2'b10; cyc(400);
    chk(npulse == 0, "R9 config change clears count", npulse, 0);

    // R1: bus short timeout, regular service keeps it quiet
    cur_req = "R1"; src_bus_clk = 1'b1; tmo_sel = 2'b01; npulse = 0;
    cyc(5000); pair(); cyc(5000); pair(); cyc(5000);
    chk(npulse == 0, "R1 service restarts", npulse, 0);

    // R3: lone 0xAA does not restart
    cur_req = "R3"; wr(8'hAA); cyc(3300);
    chk(npulse == 1, "R3 lone second key ignored", npulse, 1);

    // R2: foreign byte
    cur_req = "R2"; cyc(3); npulse = 0; wr(8'h12); cyc(1);
    chk(npulse == 1, "R2 foreign byte reset", npulse, 1);

    // R11: pair lands on the terminal step
    cur_req = "R11"; npulse = 0; wait_cnt(8190); pair(); cyc(10);
    chk(npulse == 0, "R11 service beats timeout", npulse, 0);

    // R7: window boundary with bus short
    cur_req = "R7"; window_en = 1'b1; tmo_sel = 2'b10; cyc(1); tmo_sel = 2'b01; cyc(1);
    npulse = 0; wait_cnt(6143); wr(8'h55); cyc(2);
    chk(npulse == 1, "R7 write one below window", npulse, 1);
    npulse = 0; wait_cnt(6144); pair(); cyc(2);
    chk(npulse == 0, "R7 write at window opening", npulse, 0);
    npulse = 0; wait_cnt(100); wr(8'hAA); cyc(2);
    chk(npulse == 1, "R7 early second key", npulse, 1);
    window_en = 1'b0;

    // R5: off
    cur_req = "R5"; tmo_sel = 2'b00; cyc(1); npulse = 0; wr(8'h12); cyc(9000);
    chk(npulse == 0, "R5 disabled quiet", npulse, 0);

    // R4: bus medium timeout = 65536 cycles
    cur_req = "R4"; tmo_sel = 2'b10; npulse = 0; cyc(65600);
    chk(npulse == 1, "R4 bus medium timeout", npulse, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule